// File: doc/BRIEF.md
# Serial DAC Word Loader

This block takes a parallel code from the chip's own logic and sends it to an external three-wire multiplying DAC over a serial clock, a data line and an active-low load strobe. A one-cycle `start` pulse captures the code. The block then clocks the bits out most significant first. After the last bit it pulses the load strobe, which makes the converter copy its input shift register into its output register. Once the strobe is released, a one-cycle `done` pulse tells the requester that the transfer is finished.

Every interface time minimum is a parameter counted in system-clock cycles: serial clock high time, serial clock low time, data setup, data hold and load pulse width. The data line changes only on the falling serial clock edge. The low phase lasts as long as the larger of the low-time and setup minimums. The high phase lasts as long as the larger of the high-time and hold minimums. Between transfers the serial clock rests low and the strobe rests high, so the converter neither shifts nor loads.

Top module: `serial_dac_loader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dac_sclk` is 0, `dac_ld_n` is 1, `busy` is 0 and `done` is 0.
- R2: A transfer carries exactly WORD_W bits, one per rising `dac_sclk` edge. Bit WORD_W-1 of `code` goes first and bit 0 goes last, so a receiver that shifts left on each rising edge holds `code` at the end.
- R3: Before every rising `dac_sclk` edge, `dac_sdi` has been stable for at least SETUP_CYC system cycles.
- R4: After every rising `dac_sclk` edge, `dac_sdi` stays unchanged for at least HOLD_CYC system cycles.
- R5: During a transfer, each `dac_sclk` high phase lasts at least HIGH_CYC cycles and each low phase lasts at least LOW_CYC cycles.
- R6: `dac_ld_n` falls only after the last of the WORD_W rising edges. It then stays low for at least LOAD_CYC cycles, and `dac_sclk` is low throughout that time.
- R7: `busy` goes high on the edge that accepts `start` and stays high until `dac_ld_n` returns high. On that same edge `done` goes high for exactly one cycle. The accepting edge and the `done` edge are 12*(max(LOW_CYC,SETUP_CYC)+max(HIGH_CYC,HOLD_CYC))+LOAD_CYC cycles apart when WORD_W is 12.
- R8: A `start` that arrives while `busy` or `done` is high is ignored. The word in flight and its timing are unchanged, and no new transfer follows.
- R9: Whenever `busy` is low, `dac_sclk` is 0 and `dac_ld_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send `code` |
| code | input | WORD_W | Code to send to the converter |
| dac_sclk | output | 1 | Serial clock; the converter samples on its rising edge |
| dac_sdi | output | 1 | Serial data, most significant bit first |
| dac_ld_n | output | 1 | Active-low load strobe |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A bit counter or shift register that is out of step shows up on the data line within one serial clock period. A model of the receiving register then latches a wrong code when the strobe falls, which is at most one transfer later. A phase timer that reloads the wrong value shortens a high, low or strobe phase, and the bench counts cycles to catch the first phase that comes up short. A controller that slips into the wrong state moves the `done` cycle away from the arithmetic latency, or leaves the serial clock or strobe away from its resting level while `busy` is low. Either error is flagged on the cycle it happens.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LOAD,
    ST_DONE
  } ld_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_word_shifter.sv
module dac_word_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] code,
  output logic              sdo,
  output logic              last
);

  localparam int IDX_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    if (load) begin
      word_d = code;
      idx_d  = '0;
    end else if (shift) begin
      word_d = {word_q[WORD_W-2:0], 1'b0};
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      word_q <= word_d;
      idx_q  <= idx_d;
    end
  end

  assign sdo  = word_q[WORD_W-1];
  assign last = (idx_q == IDX_W'(WORD_W - 1));

  // R2: the controller never asks for a shift past the last bit
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(WORD_W));

endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
  import dac_loader_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int LOW_CYC   = 2,
  parameter int HIGH_CYC  = 2,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int LOAD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] code,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_ld_n,
  output logic              busy,
  output logic              done
);

  localparam int LOW_N  = max_of(LOW_CYC, SETUP_CYC);
  localparam int HIGH_N = max_of(HIGH_CYC, HOLD_CYC);
  localparam int LONG_N = max_of(max_of(LOW_N, HIGH_N), LOAD_CYC);
  localparam int CNT_W  = $clog2(LONG_N + 1);

  ld_state_e        state_q, state_d;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_last;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LOW_N - 1);
        sh_load  = 1'b1;
      end
      ST_LOW: if (tmr_exp) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HIGH_N - 1);
      end
      ST_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          state_d = ST_LOAD;
          tmr_val = CNT_W'(LOAD_CYC - 1);
        end else begin
          state_d  = ST_LOW;
          tmr_val  = CNT_W'(LOW_N - 1);
          sh_shift = 1'b1;
        end
      end
      ST_LOAD: if (tmr_exp) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  dac_word_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .shift (sh_shift),
    .code  (code),
    .sdo   (dac_sdi),
    .last  (sh_last)
  );

  assign dac_sclk = (state_q == ST_HIGH);
  assign dac_ld_n = (state_q != ST_LOAD);
  assign busy     = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_LOAD);
  assign done     = (state_q == ST_DONE);

  // R6: serial clock rests low for the whole strobe
  p_ld_sclk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ld_n |-> !dac_sclk);

  // R4: data from the shifter holds still across a high phase
  p_sdi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdi));

  // R7: done lasts one cycle and follows a strobe
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_ld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(dac_ld_n));

  // R7: busy drops only into the done pulse
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R9: lines at rest outside a transfer
  p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dac_sclk && dac_ld_n));

endmodule

// File: tb/test_serial_dac_loader.sv
module test_serial_dac_loader;

  localparam int CLK_PERIOD = 10;
  localparam int W      = 12;
  localparam int T_LOW  = 2;
  localparam int T_HIGH = 2;
  localparam int T_SU   = 1;
  localparam int T_HD   = 1;
  localparam int T_LD   = 2;
  localparam int PH_LOW  = (T_LOW > T_SU) ? T_LOW : T_SU;
  localparam int PH_HIGH = (T_HIGH > T_HD) ? T_HIGH : T_HD;
  localparam int XFER    = W * (PH_LOW + PH_HIGH) + T_LD + 1;

  logic clk, rst_n, start;
  logic [W-1:0] code;
  logic dac_sclk, dac_sdi, dac_ld_n, busy, done;

  int n_cmp, n_bad;

  serial_dac_loader #(
    .WORD_W(W), .LOW_CYC(T_LOW), .HIGH_CYC(T_HIGH),
    .SETUP_CYC(T_SU), .HOLD_CYC(T_HD), .LOAD_CYC(T_LD)
  ) i_serial_dac_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code),
    .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // receiving register model and timing monitor
  logic [W-1:0] rx_sh, dac_reg;
  int rx_bits, sdi_age, since_rise, hi_cnt, lo_cnt, ld_cnt;
  logic p_sclk, p_sdi, p_ld, p_done;

  initial begin
    rx_sh = '0; dac_reg = '0; rx_bits = 0;
    sdi_age = 100; since_rise = 100; hi_cnt = 0; lo_cnt = 100; ld_cnt = 0;
    p_sclk = 1'b0; p_sdi = 1'b0; p_ld = 1'b1; p_done = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_sdi != p_sdi) sdi_age = 0; else sdi_age++;
      if (dac_sclk) since_rise++;
      if (dac_sclk && !p_sclk) begin
        check(sdi_age >= T_SU, "R3 setup", sdi_age, T_SU);
        check(lo_cnt >= T_LOW, "R5 low", lo_cnt, T_LOW);
        rx_sh = {rx_sh[W-2:0], dac_sdi};
        rx_bits++;
        since_rise = 0;
        hi_cnt = 1;
      end else if (dac_sclk) hi_cnt++;
      if (!dac_sclk && p_sclk) begin
        check(hi_cnt >= T_HIGH, "R5 high", hi_cnt, T_HIGH);
        lo_cnt = 1;
      end else if (!dac_sclk) lo_cnt++;
      if (dac_sdi != p_sdi && busy)
        check(since_rise >= T_HD, "R4 hold", since_rise, T_HD);
      if (!dac_ld_n) begin
        if (p_ld) begin
          check(rx_bits == W, "R6 bits before load", rx_bits, W);
          ld_cnt = 0;
        end
        ld_cnt++;
        check(!dac_sclk, "R6 sclk during load", dac_sclk, 0);
        dac_reg = rx_sh;
      end
      if (dac_ld_n && !p_ld) begin
        check(ld_cnt >= T_LD, "R6 load width", ld_cnt, T_LD);
        check(done, "R7 done with strobe release", done, 1);
      end
      if (done) check(!p_done, "R7 single done", p_done, 0);
      if (!busy) check(!dac_sclk && dac_ld_n, "R9 idle lines",
                       {dac_sclk, dac_ld_n}, 1);
      p_sclk = dac_sclk; p_sdi = dac_sdi; p_ld = dac_ld_n; p_done = done;
    end
  end

  // mode 0 plain, 1 start during busy, 2 start during done
  task automatic send(input logic [W-1:0] val, input int mode);
    int n;
    @(negedge clk);
    code = val; start = 1'b1;
    @(posedge clk);
    #1 rx_bits = 0;
    n = 0;
    while (n < 400) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (n == 1) check(busy, "R7 busy after accept", busy, 1);
      if (mode == 1 && n == 10) begin code = ~val; start = 1'b1; end
      if (done) break;
    end
    check(n == XFER, "R7 latency", n, XFER);
    check(dac_reg == val, "R2 latched code", dac_reg, val);
    check(rx_bits == W, "R2 bit count", rx_bits, W);
    if (mode == 1) check(dac_reg == val, "R8 start while busy", dac_reg, val);
    if (mode == 2) begin
      code = ~val; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 4; k++) begin
        check(!busy && dac_ld_n, "R8 start during done", busy, 0);
        @(negedge clk);
      end
      check(dac_reg == val, "R8 register unchanged", dac_reg, val);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; code = '0;
    repeat (3) @(negedge clk);
    check(!dac_sclk && dac_ld_n && !busy && !done, "R1 reset state",
          {dac_sclk, dac_ld_n, busy, done}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dac_sclk && dac_ld_n && !busy && !done, "R1 after release",
          {dac_sclk, dac_ld_n, busy, done}, 4'b0100);
    send(12'hFFF, 0);
    send(12'h000, 0);
    send(12'h800, 0);
    send(12'h7FF, 0);
    send(12'h555, 0);
    send(12'hAAA, 0);
    for (int i = 0; i < W; i++) send(W'(1) << i, 0);
    for (int v = 0; v < 4096; v += 37) send(W'(v), 0);
    send(12'hA5C, 1);
    send(12'h3C1, 1);
    send(12'h0F0, 2);
    send(12'hE01, 2);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule